// File: doc/BRIEF.md
# Packet-Atomic Cell Reassembly Merger

This block sits on the output side of a cell switch. Each slot may bring one fixed-size cell. The cell carries the number of the input port it came from, its incoming VC number and a flag that marks the last cell of its packet. The port and VC numbers together choose one of the per-flow reassembly queues. Those queues are linked lists threaded through one shared pool of cell slots. Each cell of a packet waits in its queue until the cell that closes the packet has arrived. Only then is the packet eligible to leave.

A merge engine takes completed packets in the order they completed. It splices each packet into a single output list, which lives in the same pool, as one unbroken run. While it does so it stamps every cell with an outgoing label read from a translation table. An entry of that table either merges all traffic to a destination onto one label, or keeps the service classes of that destination apart. The output list is drained first-in first-out, one cell per slot, whenever the link grants a slot.

When no free slot remains, an arriving cell is dropped and the rest of its packet is thrown away. Cells of that packet that were already stored are returned to the pool and never reach the output. A counter records every dropped cell.

Top module: `cell_merge_reasm`

## Requirements
- R1: The queue index is formed as {in_port, in_vci}, with the port number in the upper bits. Cells that share a VC number but arrive on different ports are reassembled as separate packets.
- R2: No cell of a packet appears at the output before that packet's end-of-packet cell has been accepted.
- R3: Each packet leaves as a contiguous run with its cells in arrival order. No other cell comes between them, and out_eop is 1 on the last cell of the run only.
- R4: Completed packets leave in the order in which their end-of-packet cells arrived, across all queues.
- R5: out_vci is {dest, qos} when the table entry of the cell's queue has its partial flag set, and {dest, 0} otherwise. dest takes the upper 3 bits and the class takes the lowest bit, so several queues can share one outgoing label.
- R6: All queued cells share 32 slots, whether they wait in reassembly queues or in the output list. An arriving cell is dropped, and drop_cnt goes up by 1, exactly when all 32 slots are in use.
- R7: After a drop, every further cell of that packet, up to and including its end-of-packet cell, is dropped and counted. The cells of that packet that were already stored are freed and never emitted. When the dropped cell is itself the end-of-packet cell, the queue accepts its next packet normally.
- R8: While out_ready is high the output list gives one cell per cycle. While out_ready is low, out_valid, out_data, out_vci and out_eop hold their values.
- R9: After reset there is no output, drop_cnt is 0 and every table entry is zero, so every label is 0.
- R10: A table write (map_we) updates one entry at the clock edge. The new entry applies to every packet whose transfer starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A cell is present in this slot |
| in_port | input | 2 | Input port number of the cell |
| in_vci | input | 2 | Incoming VC number of the cell |
| in_eop | input | 1 | Cell closes its packet |
| in_data | input | 16 | Opaque cell contents |
| map_we | input | 1 | Write one translation entry |
| map_idx | input | 4 | Queue whose entry is written |
| map_dest | input | 3 | Destination code of the entry |
| map_qos | input | 1 | Service class of the entry |
| map_partial | input | 1 | 1: keep classes apart, 0: merge by destination only |
| out_ready | input | 1 | Link grants a cell this slot |
| out_valid | output | 1 | Output list holds a cell |
| out_vci | output | 4 | Outgoing label of the head cell |
| out_eop | output | 1 | Head cell is the last of its packet |
| out_data | output | 16 | Contents of the head cell |
| drop_cnt | output | 16 | Number of cells dropped since reset |

## Verification
A broken link pointer or free-list entry shows at the ports within one packet time. The bench sees cells from the wrong packet or in the wrong order, or a lost slot that causes a drop where none should happen. A count error in the merge engine cuts a run short or overruns it. That shows at once as a misplaced out_eop or as a foreign cell inside a run. The output stream is checked cell by cell against a model built only from the order in which packets closed. A drop test then fills the pool to exactly its 32 slots, so that a single leaked or doubly freed slot moves the drop count.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

    localparam int PORT_W = 2;
    localparam int VCI_W  = 2;
    localparam int DEST_W = 3;
    localparam int QOS_W  = 1;
    localparam int DATA_W = 16;
    localparam int CELLS  = 32;   // power of two
    localparam int DROP_W = 16;

    localparam int Q_W    = PORT_W + VCI_W;
    localparam int NQ     = 1 << Q_W;
    localparam int PTR_W  = $clog2(CELLS);
    localparam int LEN_W  = $clog2(CELLS + 1);
    localparam int OVCI_W = DEST_W + QOS_W;
    localparam int SUM_W  = LEN_W + Q_W + 1;

    typedef struct packed {
        logic              partial;
        logic [DEST_W-1:0] dest;
        logic [QOS_W-1:0]  qos;
    } map_t;

    // one entry per finished (or abandoned) packet, in completion order
    typedef struct packed {
        logic             kill;
        logic [Q_W-1:0]   q;
        logic [LEN_W-1:0] len;
    } done_t;

    typedef enum logic {MV_IDLE, MV_RUN} mv_state_t;

    function automatic logic [OVCI_W-1:0] out_label(map_t m);
        return {m.dest, (m.partial ? m.qos : {QOS_W{1'b0}})};
    endfunction

endpackage

// File: rtl/mrg_free_list.sv
module mrg_free_list #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       take,
    output logic [$clog2(DEPTH)-1:0]   head_idx,
    output logic                       avail,
    input  logic                       rel_a,
    input  logic [$clog2(DEPTH)-1:0]   idx_a,
    input  logic                       rel_b,
    input  logic [$clog2(DEPTH)-1:0]   idx_b
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] slot [DEPTH];
    logic [PW-1:0] rd, wr;
    logic [CW-1:0] cnt;

    assign head_idx = slot[rd];
    assign avail    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= PW'(i);
            rd  <= '0;
            wr  <= '0;
            cnt <= CW'(DEPTH);
        end else begin
            if (rel_a) slot[wr] <= idx_a;
            if (rel_b) slot[rel_a ? wr + PW'(1) : wr] <= idx_b;
            wr  <= wr + PW'(rel_a) + PW'(rel_b);
            rd  <= rd + PW'(take);
            cnt <= cnt + CW'(rel_a) + CW'(rel_b) - CW'(take);
        end
    end

    // R6
    take_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> cnt != '0);

    // R6
    free_overfill_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_a || rel_b) |-> (int'(cnt) + int'(rel_a) + int'(rel_b) - int'(take) <= DEPTH));

endmodule

// File: rtl/mrg_sync_fifo.sv
module mrg_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd, wr;
    logic [CW-1:0] cnt;

    assign dout  = mem[rd];
    assign empty = (cnt == '0);

    always_ff @(posedge clk) begin
        if (push) mem[wr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd  <= '0;
            wr  <= '0;
            cnt <= '0;
        end else begin
            wr  <= wr + PW'(push);
            rd  <= rd + PW'(pop);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // R4
    order_fifo_over_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (int'(cnt) < DEPTH) || pop);

    // R4
    order_fifo_under_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/cell_merge_reasm.sv
module cell_merge_reasm
    import mrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_port,
    input  logic [VCI_W-1:0]  in_vci,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              map_we,
    input  logic [Q_W-1:0]    map_idx,
    input  logic [DEST_W-1:0] map_dest,
    input  logic [QOS_W-1:0]  map_qos,
    input  logic              map_partial,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [OVCI_W-1:0] out_vci,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    output logic [DROP_W-1:0] drop_cnt
);
    // shared cell pool
    logic [DATA_W-1:0] cell_data [CELLS];
    logic [PTR_W-1:0]  cell_next [CELLS];
    logic [OVCI_W-1:0] cell_lab  [CELLS];
    logic              cell_eop  [CELLS];

    map_t map_tbl [NQ];

    // reassembly queues
    logic [PTR_W-1:0] q_head [NQ];
    logic [PTR_W-1:0] q_tail [NQ];
    logic [LEN_W-1:0] q_cnt  [NQ];
    logic [LEN_W-1:0] q_open [NQ];
    logic [NQ-1:0]    q_discard;

    // output list
    logic [PTR_W-1:0] o_head, o_tail;
    logic [LEN_W-1:0] o_cnt;

    // merge engine
    mv_state_t         mv_state;
    done_t             cur;
    logic [LEN_W-1:0]  rem;
    logic [OVCI_W-1:0] run_lab;

    // arrival decode
    logic [Q_W-1:0]   in_q;
    logic             fl_avail;
    logic [PTR_W-1:0] fl_idx;
    logic             drop_now, accept, new_drop;

    assign in_q     = {in_port, in_vci};
    assign drop_now = in_valid && (q_discard[in_q] || !fl_avail);
    assign accept   = in_valid && !drop_now;
    assign new_drop = drop_now && !q_discard[in_q];

    // completion fifo
    logic  cf_push, cf_pop, cf_empty;
    done_t cf_din, cf_head;

    always_comb begin
        cf_push = 1'b0;
        cf_din  = '0;
        if (accept && in_eop) begin
            cf_push = 1'b1;
            cf_din  = '{kill: 1'b0, q: in_q, len: q_open[in_q] + LEN_W'(1)};
        end else if (new_drop && q_open[in_q] != '0) begin
            cf_push = 1'b1;
            cf_din  = '{kill: 1'b1, q: in_q, len: q_open[in_q]};
        end
    end

    // merge step control
    logic             mv_stall, mv_step, mv_last, o_push, o_pop, kill_free;
    logic [PTR_W-1:0] mv_cell;

    assign cf_pop    = (mv_state == MV_IDLE) && !cf_empty;
    assign mv_stall  = in_valid && (in_q == cur.q);
    assign mv_step   = (mv_state == MV_RUN) && !mv_stall;
    assign mv_cell   = q_head[cur.q];
    assign mv_last   = (rem == LEN_W'(1));
    assign o_push    = mv_step && !cur.kill;
    assign kill_free = mv_step && cur.kill;

    assign out_valid = (o_cnt != '0);
    assign o_pop     = out_valid && out_ready;
    assign out_data  = cell_data[o_head];
    assign out_vci   = cell_lab[o_head];
    assign out_eop   = cell_eop[o_head];

    mrg_free_list #(.DEPTH(CELLS)) u_free (
        .clk      (clk),
        .rst      (rst),
        .take     (accept),
        .head_idx (fl_idx),
        .avail    (fl_avail),
        .rel_a    (o_pop),
        .idx_a    (o_head),
        .rel_b    (kill_free),
        .idx_b    (mv_cell)
    );

    mrg_sync_fifo #(.W($bits(done_t)), .DEPTH(CELLS)) u_done (
        .clk   (clk),
        .rst   (rst),
        .push  (cf_push),
        .din   (cf_din),
        .pop   (cf_pop),
        .dout  (cf_head),
        .empty (cf_empty)
    );

    // pool contents: no reset needed, validity is tracked by counts
    always_ff @(posedge clk) begin
        if (accept) begin
            cell_data[fl_idx] <= in_data;
            if (q_cnt[in_q] != '0) cell_next[q_tail[in_q]] <= fl_idx;
        end
        if (o_push) begin
            cell_lab[mv_cell] <= run_lab;
            cell_eop[mv_cell] <= mv_last;
            if (o_cnt != '0) cell_next[o_tail] <= mv_cell;
        end
    end

    // translation table
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NQ; i++) map_tbl[i] <= '0;
        end else if (map_we) begin
            map_tbl[map_idx] <= '{partial: map_partial, dest: map_dest, qos: map_qos};
        end
    end

    // reassembly queue bookkeeping; arrival and merge never touch the same queue
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NQ; i++) begin
                q_head[i] <= '0;
                q_tail[i] <= '0;
                q_cnt[i]  <= '0;
                q_open[i] <= '0;
            end
            q_discard <= '0;
            drop_cnt  <= '0;
        end else begin
            if (accept) begin
                if (q_cnt[in_q] == '0) q_head[in_q] <= fl_idx;
                q_tail[in_q] <= fl_idx;
                q_cnt[in_q]  <= q_cnt[in_q] + LEN_W'(1);
                q_open[in_q] <= in_eop ? '0 : q_open[in_q] + LEN_W'(1);
            end
            if (drop_now) begin
                drop_cnt <= drop_cnt + DROP_W'(1);
                if (q_discard[in_q]) begin
                    if (in_eop) q_discard[in_q] <= 1'b0;
                end else begin
                    q_open[in_q] <= '0;
                    if (!in_eop) q_discard[in_q] <= 1'b1;
                end
            end
            if (mv_step) begin
                q_head[cur.q] <= cell_next[mv_cell];
                q_cnt[cur.q]  <= q_cnt[cur.q] - LEN_W'(1);
            end
        end
    end

    // output list
    always_ff @(posedge clk) begin
        if (rst) begin
            o_head <= '0;
            o_tail <= '0;
            o_cnt  <= '0;
        end else begin
            o_cnt <= o_cnt + LEN_W'(o_push) - LEN_W'(o_pop);
            if (o_pop) o_head <= cell_next[o_head];
            if (o_push) begin
                o_tail <= mv_cell;
                if (o_cnt == '0 || (o_cnt == LEN_W'(1) && o_pop)) o_head <= mv_cell;
            end
        end
    end

    // merge engine: one packet at a time, label latched at run start
    always_ff @(posedge clk) begin
        if (rst) begin
            mv_state <= MV_IDLE;
            cur      <= '0;
            rem      <= '0;
            run_lab  <= '0;
        end else begin
            case (mv_state)
                MV_IDLE: if (cf_pop) begin
                    cur      <= cf_head;
                    rem      <= cf_head.len;
                    run_lab  <= out_label(map_tbl[cf_head.q]);
                    mv_state <= MV_RUN;
                end
                MV_RUN: if (mv_step) begin
                    rem <= rem - LEN_W'(1);
                    if (mv_last) mv_state <= MV_IDLE;
                end
                default: mv_state <= MV_IDLE;
            endcase
        end
    end

    // occupancy across reassembly queues and output list
    logic [SUM_W-1:0] held;
    always_comb begin
        held = SUM_W'(o_cnt);
        for (int i = 0; i < NQ; i++) held = held + SUM_W'(q_cnt[i]);
    end

    // R6
    pool_bound_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> held < SUM_W'(CELLS));

    // R3
    run_source_chk: assert property (@(posedge clk) disable iff (rst)
        mv_step |-> q_cnt[cur.q] != '0);

    // R7
    drop_source_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt != $past(drop_cnt)) |-> $past(in_valid));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data)
                                      && $stable(out_vci) && $stable(out_eop));

endmodule

// File: tb/tb_cell_merge_reasm.sv
module tb_cell_merge_reasm;
    import mrg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [PORT_W-1:0] in_port = '0;
    logic [VCI_W-1:0]  in_vci = '0;
    logic              in_eop = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              map_we = 1'b0;
    logic [Q_W-1:0]    map_idx = '0;
    logic [DEST_W-1:0] map_dest = '0;
    logic [QOS_W-1:0]  map_qos = '0;
    logic              map_partial = 1'b0;
    logic              out_ready = 1'b0;
    logic              out_valid;
    logic [OVCI_W-1:0] out_vci;
    logic              out_eop;
    logic [DATA_W-1:0] out_data;
    logic [DROP_W-1:0] drop_cnt;

    cell_merge_reasm dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port), .in_vci(in_vci),
        .in_eop(in_eop), .in_data(in_data), .map_we(map_we), .map_idx(map_idx),
        .map_dest(map_dest), .map_qos(map_qos), .map_partial(map_partial),
        .out_ready(out_ready), .out_valid(out_valid), .out_vci(out_vci),
        .out_eop(out_eop), .out_data(out_data), .drop_cnt(drop_cnt)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_vec = 0, n_bad = 0, cyc = 0, rdy_mode = 1;
    bit finished = 0;
    int exp_data [2048];
    int exp_vci  [2048];
    int exp_eop  [2048];
    int exp_wr = 0, exp_rd = 0;
    int pend [NQ][64];
    int pend_n [NQ];
    bit pend_dead [NQ];
    int tb_dest [NQ];
    int tb_qos  [NQ];
    int tb_part [NQ];
    int seqv = 1;
    string vci_req = "R9";

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // R5: label = dest*2 + (partial ? qos : 0)
    function automatic int exp_lab(int q);
        return tb_dest[q] * 2 + (tb_part[q] != 0 ? tb_qos[q] : 0);
    endfunction

    always @(posedge clk) begin
        #2;
        cyc++;
        case (rdy_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = (cyc % 3) != 0;
        endcase
        if (cyc > 100000 && !finished) begin
            n_bad++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    // output scoreboard (R2 R3 R4 R5)
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_rd >= exp_wr) begin
                check(0, "R2", "cell without completed packet", int'(out_data), -1);
            end else begin
                check(int'(out_data) == exp_data[exp_rd], "R3 R4", "cell order",
                      int'(out_data), exp_data[exp_rd]);
                check(int'(out_vci) == exp_vci[exp_rd], vci_req, "outgoing label",
                      int'(out_vci), exp_vci[exp_rd]);
                check(int'(out_eop) == exp_eop[exp_rd], "R3", "end marker",
                      int'(out_eop), exp_eop[exp_rd]);
                exp_rd++;
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_eop   = 1'b0;
        end
    endtask

    // R1: queue index is {port, vci}
    task automatic send_cell(int q, bit eop, bit dead);
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_port  = PORT_W'(q >> VCI_W);
        in_vci   = VCI_W'(q);
        in_eop   = eop;
        in_data  = DATA_W'(seqv);
        if (dead) pend_dead[q] = 1;
        pend[q][pend_n[q]] = seqv;
        pend_n[q]++;
        seqv++;
        if (eop) begin
            if (!pend_dead[q]) begin
                for (int k = 0; k < pend_n[q]; k++) begin
                    exp_data[exp_wr] = pend[q][k];
                    exp_vci[exp_wr]  = exp_lab(q);
                    exp_eop[exp_wr]  = (k == pend_n[q] - 1) ? 1 : 0;
                    exp_wr++;
                end
            end
            pend_n[q]    = 0;
            pend_dead[q] = 0;
        end
    endtask

    task automatic write_map(int q, int dest, int qos, int part);
        @(posedge clk); #2;
        map_we      = 1'b1;
        map_idx     = Q_W'(q);
        map_dest    = DEST_W'(dest);
        map_qos     = QOS_W'(qos);
        map_partial = (part != 0);
        @(posedge clk); #2;
        map_we = 1'b0;
        tb_dest[q] = dest;
        tb_qos[q]  = qos;
        tb_part[q] = part;
    endtask

    task automatic wait_drain();
        int t = 0;
        while (exp_rd < exp_wr && t < 5000) begin
            @(posedge clk);
            t++;
        end
        idle(6);
        @(negedge clk);
        check(exp_rd == exp_wr, "R3", "cells still missing", exp_rd, exp_wr);
        check(out_valid == 1'b0, "R3", "extra cell after drain", int'(out_valid), 0);
    endtask

    initial begin
        for (int q = 0; q < NQ; q++) begin
            pend_n[q] = 0; pend_dead[q] = 0;
            tb_dest[q] = 0; tb_qos[q] = 0; tb_part[q] = 0;
        end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        check(drop_cnt == '0, "R9", "drop_cnt after reset", int'(drop_cnt), 0);

        // R9: zeroed table gives label 0
        send_cell(5, 1, 0);
        idle(1);
        wait_drain();

        // program table: many queues share labels
        vci_req = "R5";
        for (int q = 0; q < NQ; q++) write_map(q, q % 3, q % 2, (q >= 8) ? 1 : 0);

        // sweep: four queues with the same VCI on different ports, interleaved (R1 R3 R4 R5)
        for (int len = 1; len <= 4; len++) begin
            rdy_mode = (len % 2 == 1) ? 2 : 1;
            for (int g = 0; g < 4; g++) begin
                for (int step = 0; step < len + 1; step++) begin
                    for (int k = 0; k < 4; k++) begin
                        int lk = len + (k % 2);
                        if (step < lk) begin
                            send_cell(g + 4 * k, step == lk - 1, 0);
                            idle(1);
                        end
                    end
                end
            end
            wait_drain();
        end
        rdy_mode = 1;

        // R10: rewrite one entry, later packets take the new label
        vci_req = "R10";
        write_map(0, 7, 1, 1);
        send_cell(0, 0, 0); idle(1);
        send_cell(0, 1, 0); idle(1);
        wait_drain();
        vci_req = "R5";

        // R2: open packet is not forwarded
        send_cell(7, 0, 0); idle(1);
        send_cell(7, 0, 0);
        idle(20);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", "cut-through cell seen", int'(out_valid), 0);
        send_cell(7, 1, 0);
        idle(1);
        wait_drain();

        // R8: hold while not granted, then one cell per cycle
        @(negedge clk); rdy_mode = 0;
        for (int k = 0; k < 3; k++) begin send_cell(3, k == 2, 0); idle(1); end
        for (int k = 0; k < 2; k++) begin send_cell(6, k == 1, 0); idle(1); end
        for (int k = 0; k < 4; k++) begin send_cell(9, k == 3, 0); idle(1); end
        idle(20);
        begin
            int held_d;
            int nposedge;
            int target;
            @(negedge clk);
            check(out_valid == 1'b1, "R8", "valid while held", int'(out_valid), 1);
            held_d = int'(out_data);
            check(held_d == exp_data[exp_rd], "R8", "head while held", held_d, exp_data[exp_rd]);
            idle(3);
            @(negedge clk);
            check(int'(out_data) == held_d, "R8", "head stable", int'(out_data), held_d);
            target = exp_wr;
            rdy_mode = 1;
            nposedge = 0;
            do begin
                @(posedge clk);
                nposedge++;
            end while (exp_rd < target && nposedge < 100);
            check(nposedge == 10, "R8", "drain cycles for 9 cells", nposedge, 10);
        end
        wait_drain();

        // R6 R7: fill the pool exactly
        @(negedge clk); rdy_mode = 0;
        for (int k = 0; k < 30; k++) send_cell(0, k == 29, 0);
        for (int k = 0; k < 4; k++) send_cell(1, k == 3, 1);
        idle(3);
        @(negedge clk);
        check(int'(drop_cnt) == 2, "R7", "drops for overflowed packet", int'(drop_cnt), 2);
        idle(50);
        send_cell(1, 0, 0);
        send_cell(1, 1, 0);
        idle(3);
        @(negedge clk);
        check(int'(drop_cnt) == 2, "R7", "freed slots reused", int'(drop_cnt), 2);
        send_cell(2, 1, 1);
        idle(3);
        @(negedge clk);
        check(int'(drop_cnt) == 3, "R6", "drop on full pool", int'(drop_cnt), 3);
        @(negedge clk); rdy_mode = 1;
        wait_drain();
        send_cell(2, 0, 0);
        send_cell(2, 1, 0);
        idle(3);
        wait_drain();
        @(negedge clk);
        check(int'(drop_cnt) == 3, "R7", "queue accepts after dropped end cell", int'(drop_cnt), 3);

        finish_run();
    end

endmodule